// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block takes a low-power SDRAM from power-on to a usable state. When reset is released it drives the memory command pins through the fixed start-up order. First it holds a stable no-operation interval. Then it precharges every bank and issues a set number of auto-refresh commands. Then it loads the standard mode word, and last it loads the extended mode word, which the memory selects through its bank-address pins. The wait after each command is a parameter in clock cycles. The number of refreshes is a parameter, and any value below two is raised to two.

The two mode words are built from plain configuration inputs: CAS latency, burst-length code, burst type, write-burst mode, output drive strength and the partial-array self-refresh area. The `ready` output rises once the wait after the extended load has elapsed, and it stays high until the next reset. While `ready` is high the sequencer drives only no-operation commands, and a normal controller takes over the pins. All pins are registered. Asserting reset at any point returns the block to the start of the sequence.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, the pins show a no-operation command (chip select low, RAS, CAS and WE high), clock enable is high, bank and address are zero and `ready` is low.
- R2: After reset is released, exactly SETTLE_CYC no-operation cycles appear. The next cycle carries precharge-all: chip select, RAS and WE low, CAS high, address bit 10 high, all other address bits zero and bank zero.
- R3: Exactly TRP_CYC cycles after the precharge-all, an auto-refresh appears: chip select, RAS and CAS low, WE high, bank and address zero.
- R4: Exactly NUM_REF auto-refreshes are issued, each TRFC_CYC cycles after the one before. The standard mode load follows TRFC_CYC cycles after the last refresh.
- R5: A mode load has chip select, RAS, CAS and WE all low. The standard word has bank 00. Address bits 2..0 carry the burst-length code, bit 3 the burst type, bits 6..4 the CAS latency as a three-bit number (1, 2 or 3), and bit 9 the write-burst mode. Bits 8, 7, 11 and 10 are zero.
- R6: Exactly TMRD_CYC cycles after the standard load, the extended load appears with bank 10. Address bits 2..0 carry the partial-array code (000 full, 001 half, 010 quarter) and bits 6..5 the drive strength (00 full, 01 half, 10 quarter, 11 eighth). All other address bits are zero.
- R7: `ready` rises exactly TMRD_CYC cycles after the extended load and then stays high with no-operation on the pins. Before that it is low.
- R8: Clock enable stays high throughout. Every cycle that carries none of the commands above is a no-operation with zero bank and address.
- R9: Asserting reset in the middle of the sequence returns the pins to the R1 state. After release the complete sequence runs again from the settle interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_burst_code | input | 3 | Burst-length code for address bits 2..0 |
| cfg_burst_ilv | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cfg_single_wr | input | 1 | Write-burst mode: 1 makes writes single-beat |
| cfg_drive | input | 2 | Output drive-strength code |
| cfg_pasr | input | 3 | Partial-array self-refresh code |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | 12 | Address / mode word |
| ready | output | 1 | Start-up complete |

## Verification
The sharpest coincidence is at the end of each refresh wait. In that same cycle the gap timer runs out and the refresh counter is compared with its limit, and that comparison decides between a further refresh and the mode load. The bench runs with three refreshes and predicts the cycle of every command from the parameters. An off-by-one in either the counter or the timer therefore shifts a command to the wrong cycle, and the bench flags it. A second coincidence, reset arriving while a gap is running, is provoked by asserting reset partway through the refresh phase. The bench then checks that the next run reproduces the whole timeline from the settle interval.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_PRE,
    ST_PRE_GAP,
    ST_REF,
    ST_REF_GAP,
    ST_MODE,
    ST_MODE_GAP,
    ST_EXT,
    ST_EXT_GAP,
    ST_READY
  } boot_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] pin_cmd_t;
  localparam pin_cmd_t CMD_NOP  = 4'b0111;
  localparam pin_cmd_t CMD_PALL = 4'b0010;
  localparam pin_cmd_t CMD_AREF = 4'b0001;
  localparam pin_cmd_t CMD_LOAD = 4'b0000;

  localparam logic [1:0] BANK_STD = 2'b00;
  localparam logic [1:0] BANK_EXT = 2'b10;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int at_least(input int v, input int floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

endpackage

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= W'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/boot_word_build.sv
module boot_word_build #(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        cas_lat,
  input  logic [2:0]        burst_code,
  input  logic              burst_ilv,
  input  logic              single_wr,
  input  logic [1:0]        drive,
  input  logic [2:0]        pasr,
  output logic [ADDR_W-1:0] std_word,
  output logic [ADDR_W-1:0] ext_word
);
  always_comb begin
    std_word      = '0;
    std_word[2:0] = burst_code;
    std_word[3]   = burst_ilv;
    std_word[6:4] = {1'b0, cas_lat};
    std_word[9]   = single_wr;
  end

  always_comb begin
    ext_word      = '0;
    ext_word[2:0] = pasr;
    ext_word[6:5] = drive;
  end
endmodule

// File: rtl/boot_pin_drive.sv
module boot_pin_drive
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  boot_state_e       state,
  input  logic [ADDR_W-1:0] std_word,
  input  logic [ADDR_W-1:0] ext_word,
  output logic              cke,
  output pin_cmd_t          cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  pin_cmd_t          cmd_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = BANK_STD;
    addr_d = '0;
    unique case (state)
      ST_PRE:  begin cmd_d = CMD_PALL; addr_d = ALL_BANKS; end
      ST_REF:  cmd_d = CMD_AREF;
      ST_MODE: begin cmd_d = CMD_LOAD; addr_d = std_word; end
      ST_EXT:  begin cmd_d = CMD_LOAD; addr_d = ext_word; ba_d = BANK_EXT; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke   <= 1'b1;
      cmd   <= CMD_NOP;
      ba    <= '0;
      addr  <= '0;
      ready <= 1'b0;
    end else begin
      cke   <= 1'b1;
      cmd   <= cmd_d;
      ba    <= ba_d;
      addr  <= addr_d;
      ready <= (state == ST_READY);
    end
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int SETTLE_CYC = 40000,
  parameter int TRP_CYC    = 5,
  parameter int TRFC_CYC   = 16,
  parameter int TMRD_CYC   = 2,
  parameter int NUM_REF    = 2,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_burst_code,
  input  logic              cfg_burst_ilv,
  input  logic              cfg_single_wr,
  input  logic [1:0]        cfg_drive,
  input  logic [2:0]        cfg_pasr,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ready
);
  localparam int SETTLE = at_least(SETTLE_CYC, 1);
  localparam int GAP_RP = at_least(TRP_CYC, 2);
  localparam int GAP_RF = at_least(TRFC_CYC, 2);
  localparam int GAP_MR = at_least(TMRD_CYC, 2);
  localparam int REFS   = at_least(NUM_REF, 2);
  localparam int TOP_V  = max_of(max_of(SETTLE, GAP_RP), max_of(GAP_RF, GAP_MR));
  localparam int TW     = $clog2(TOP_V + 1);
  localparam int RW     = $clog2(REFS + 1);

  localparam logic [TW-1:0] LD_RP = TW'(GAP_RP - 2);
  localparam logic [TW-1:0] LD_RF = TW'(GAP_RF - 2);
  localparam logic [TW-1:0] LD_MR = TW'(GAP_MR - 2);
  localparam logic [RW-1:0] REF_LAST = RW'(REFS);

  boot_state_e   state_q, state_d;
  logic [RW-1:0] refs_q;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  logic [ADDR_W-1:0] std_word, ext_word;
  pin_cmd_t          pin_cmd;

  boot_gap_timer #(.W(TW), .RST_VAL(SETTLE - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_SETTLE:   if (tmr_zero) state_d = ST_PRE;
      ST_PRE:      begin tmr_load = 1'b1; tmr_val = LD_RP; state_d = ST_PRE_GAP; end
      ST_PRE_GAP:  if (tmr_zero) state_d = ST_REF;
      ST_REF:      begin tmr_load = 1'b1; tmr_val = LD_RF; state_d = ST_REF_GAP; end
      ST_REF_GAP:  if (tmr_zero) state_d = (refs_q == REF_LAST) ? ST_MODE : ST_REF;
      ST_MODE:     begin tmr_load = 1'b1; tmr_val = LD_MR; state_d = ST_MODE_GAP; end
      ST_MODE_GAP: if (tmr_zero) state_d = ST_EXT;
      ST_EXT:      begin tmr_load = 1'b1; tmr_val = LD_MR; state_d = ST_EXT_GAP; end
      ST_EXT_GAP:  if (tmr_zero) state_d = ST_READY;
      default:     state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SETTLE;
      refs_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REF) refs_q <= refs_q + 1'b1;
    end
  end

  boot_word_build #(.ADDR_W(ADDR_W)) u_words (
    .cas_lat    (cfg_cas_lat),
    .burst_code (cfg_burst_code),
    .burst_ilv  (cfg_burst_ilv),
    .single_wr  (cfg_single_wr),
    .drive      (cfg_drive),
    .pasr       (cfg_pasr),
    .std_word   (std_word),
    .ext_word   (ext_word)
  );

  boot_pin_drive #(.ADDR_W(ADDR_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .std_word (std_word),
    .ext_word (ext_word),
    .cke      (mem_cke),
    .cmd      (pin_cmd),
    .ba       (mem_ba),
    .addr     (mem_addr),
    .ready    (ready)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = pin_cmd;
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cke,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic [1:0]        mem_ba,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ready
);
  logic [3:0] pins;
  logic is_nop, is_pall, is_aref, is_load;
  assign pins    = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_pall = (pins == 4'b0010);
  assign is_aref = (pins == 4'b0001);
  assign is_load = (pins == 4'b0000);

  assert_cke_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke);

  assert_legal_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_pall || is_aref || is_load);

  assert_pall_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> (mem_addr == (ADDR_W'(1) << 10)) && (mem_ba == 2'b00));

  assert_aref_then_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_aref |=> is_nop);

  assert_load_then_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> is_nop);

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> is_nop && (mem_addr == '0) && (mem_ba == 2'b00));

  assert_load_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |-> (mem_ba == 2'b00) || (mem_ba == 2'b10));
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_cke   (mem_cke),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .mem_ba    (mem_ba),
  .mem_addr  (mem_addr),
  .ready     (ready)
);

// File: tb/sim_sdram_boot_seq.sv
`timescale 1ns/1ps
module sim_sdram_boot_seq;
  localparam int S    = 6;
  localparam int TRP  = 3;
  localparam int TRFC = 4;
  localparam int TMRD = 2;
  localparam int NREF = 3;
  localparam int AW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cl = 2'd1;
  logic [2:0] bl = 3'd0;
  logic bt = 1'b0, wb = 1'b0;
  logic [1:0] ds = 2'd0;
  logic [2:0] pa = 3'd0;

  logic cke, cs_n, ras_n, cas_n, we_n, rdy;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sdram_boot_seq #(
    .SETTLE_CYC(S), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD),
    .NUM_REF(NREF), .ADDR_W(AW)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_cas_lat(cl), .cfg_burst_code(bl), .cfg_burst_ilv(bt),
    .cfg_single_wr(wb), .cfg_drive(ds), .cfg_pasr(pa),
    .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n),
    .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr), .ready(rdy)
  );

  // observed vector: {cke, cs_n, ras_n, cas_n, we_n, ba, addr, ready}
  function automatic logic [19:0] pack(input logic [3:0] c, input logic [1:0] b,
                                       input logic [11:0] a, input logic d);
    return {1'b1, c, b, a, d};
  endfunction

  task automatic check(input string req, input logic [19:0] exp_v);
    logic [19:0] act;
    act = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, rdy};
    checks++;
    if (act !== exp_v) begin
      fails++;
      if (fails < 30)
        $display("FAIL %s cycle-check: actual %h expected %h (cl=%0d bl=%0d bt=%0d wb=%0d ds=%0d pa=%0d)",
                 req, act, exp_v, cl, bl, bt, wb, ds, pa);
    end
  endtask

  // hold reset, check the R1 state, release at a negedge
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", pack(4'b0111, 2'b00, 12'h000, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // run the sequence for up to stop_at cycles after release, checking each cycle
  task automatic run_checked(input int stop_at);
    int t_pre, t_mode, t_ext, t_rdy;
    logic [11:0] w_std, w_ext;
    t_pre  = S + 1;
    t_mode = t_pre + TRP + NREF * TRFC;
    t_ext  = t_mode + TMRD;
    t_rdy  = t_ext + TMRD;
    w_std  = {2'b00, wb, 2'b00, 1'b0, cl, bt, bl};
    w_ext  = {5'b00000, ds, 2'b00, pa};
    for (int i = 1; i <= t_rdy + 2 && i <= stop_at; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == t_pre)
        check("R2", pack(4'b0010, 2'b00, 12'h400, 1'b0));
      else if (i > t_pre && i < t_mode && ((i - t_pre - TRP) % TRFC) == 0 && i >= t_pre + TRP)
        check((i == t_pre + TRP) ? "R3" : "R4", pack(4'b0001, 2'b00, 12'h000, 1'b0));
      else if (i == t_mode)
        check("R5", pack(4'b0000, 2'b00, w_std, 1'b0));
      else if (i == t_ext)
        check("R6", pack(4'b0000, 2'b10, w_ext, 1'b0));
      else if (i >= t_rdy)
        check("R7", pack(4'b0111, 2'b00, 12'h000, 1'b1));
      else
        check("R8", pack(4'b0111, 2'b00, 12'h000, 1'b0));
    end
  endtask

  initial begin
    // R9: abandon a run mid-refresh, then expect the full timeline again
    do_reset();
    run_checked(S + TRP + TRFC + 2);
    do_reset();
    run_checked(1000);

    for (int c = 1; c <= 3; c++)
      for (int b = 0; b < 5; b++)
        for (int t = 0; t < 2; t++)
          for (int w = 0; w < 2; w++)
            for (int d = 0; d < 4; d++)
              for (int p = 0; p < 3; p++) begin
                cl = 2'(c);
                bl = (b == 4) ? 3'd7 : 3'(b);
                bt = 1'(t);
                wb = 1'(w);
                ds = 2'(d);
                pa = 3'(p);
                do_reset();
                run_checked(1000);
              end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule